// File: doc/BRIEF.md
# Programmable Watchdog Timer

This block is a memory-mapped watchdog. A 16-bit counter counts down on a tick. The tick comes from two stages in series: an 8-bit programmable prescaler, then a power-of-two divider with four settings. Software sets a reload value, the prescale field, the divider setting and the enable. It also chooses what happens on expiry: a sticky interrupt request, a fixed-length reset request pulse, both, or neither.

Software services the watchdog by writing the counter register. That write replaces the count at once. When a tick finds the counter at zero, the timer expires and the counter reloads from the reload register. The register port is synchronous and byte-addressed. It has an address, a write strobe, write data and combinational read data.

Top module: `wdog_timer`

## Requirements
- R1: After synchronous reset, the control word reads 0x8021 and both the reload and counter registers read 0x8000. `irq` and `rst_req` are low.
- R2: The control word is at address 0x00. Its fields are:
  - bit 0: reset request on expiry.
  - bit 1: write 1 to clear the interrupt flag; reads as 0.
  - bit 2: interrupt on expiry.
  - bits 4:3: divider select.
  - bit 5: counting enable.
  - bits 15:8: prescale field P.
  - bits 7:6: read as 0.
  The reload register is at 0x04 and the live counter at 0x08. Each reads back its current 16-bit value.
- R3: Reads from any other address return 0. Writes to any other address change no register.
- R4: While enabled, the counter steps down by one every (P+1)·2^(4+S) clocks, where S is the divider select. A 0-to-1 change of the enable bit clears the prescaler and the divider, so the first step comes one full period after enabling.
- R5: A write to the counter register loads the written value on that clock edge. If a tick falls on the same edge, the write takes priority.
- R6: A tick that finds the counter at zero is an expiry. On expiry the counter reloads from the reload register.
- R7: If bit 2 is set, expiry sets a sticky interrupt flag on `irq`. The flag stays set until software writes the control word with bit 1 set.
- R8: If bit 0 is set, expiry drives `rst_req` high for exactly 128 clocks, starting at the expiry edge.
- R9: With the enable bit clear, the counter holds its value. With both the enable and reset bits clear, no reset request is ever raised.
- R10: Without bit 2, expiry leaves `irq` low. Without bit 0, expiry leaves `rst_req` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | 8 | Byte address of the register |
| wr_en | input | 1 | Write strobe |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr` (combinational) |
| irq | output | 1 | Sticky expiry interrupt request |
| rst_req | output | 1 | Reset request pulse |

## Verification
Assertions check these on every cycle:
- the counter load and its priority over a tick;
- the reload on expiry;
- setting and holding of the interrupt flag;
- the start of the reset pulse, and that it never starts without an armed expiry;
- the freeze while disabled;
- the clean prescaler state when enable rises;
- that stray writes leave the registers alone.

Only the bench scenarios can show the rest:
- the exact step period for a given prescale and divider;
- the full 128-clock pulse length;
- the reset values;
- the register read map.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int PRE_W = 8;
  localparam int DIV_W = 7;

  localparam logic [7:0]  OFS_CTRL   = 8'h00;
  localparam logic [7:0]  OFS_RELOAD = 8'h04;
  localparam logic [7:0]  OFS_COUNT  = 8'h08;
  localparam logic [15:0] CTRL_INIT  = 16'h8021;

  // Control word layout; bit positions are part of the software contract.
  typedef struct packed {
    logic [PRE_W-1:0] pre;
    logic [1:0]       pad_hi;
    logic             en;
    logic [1:0]       div_sel;
    logic             int_en;
    logic             pad_lo;
    logic             rst_en;
  } ctrl_t;

  // Keep only the stored fields of a written control word.
  function automatic ctrl_t to_ctrl(input logic [15:0] w);
    ctrl_t c;
    c        = ctrl_t'(w);
    c.pad_hi = '0;
    c.pad_lo = '0;
    return c;
  endfunction

  // Divider terminal mask: 16, 32, 64 or 128 input steps.
  function automatic logic [DIV_W-1:0] div_mask(input logic [1:0] sel);
    logic [7:0] span;
    span = 8'd16 << sel;
    return DIV_W'(span - 8'd1);
  endfunction
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  input  logic [CNT_W-1:0]  cnt_val,
  output ctrl_t             ctrl,
  output logic [CNT_W-1:0]  reload,
  output logic              cnt_wr,
  output logic              irq_clr,
  output logic [DATA_W-1:0] rdata
);
  localparam logic [CNT_W-1:0] RELOAD_INIT = CNT_W'(1) << (CNT_W - 1);

  logic hit_ctrl, hit_reload, hit_count, hit_any;
  logic unused_bits;

  assign hit_ctrl    = (addr == ADDR_W'(OFS_CTRL));
  assign hit_reload  = (addr == ADDR_W'(OFS_RELOAD));
  assign hit_count   = (addr == ADDR_W'(OFS_COUNT));
  assign hit_any     = hit_ctrl || hit_reload || hit_count;
  assign cnt_wr      = wr_en && hit_count;
  assign irq_clr     = wr_en && hit_ctrl && wdata[1];
  assign unused_bits = ^wdata[7:6];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl   <= to_ctrl(CTRL_INIT);
      reload <= RELOAD_INIT;
    end else if (wr_en) begin
      if (hit_ctrl)   ctrl   <= to_ctrl(wdata[15:0]);
      if (hit_reload) reload <= wdata[CNT_W-1:0];
    end
  end

  always_comb begin
    rdata = '0;
    if (hit_ctrl)        rdata = DATA_W'(ctrl);
    else if (hit_reload) rdata = DATA_W'(reload);
    else if (hit_count)  rdata = DATA_W'(cnt_val);
  end

  // R3
  stray_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !hit_any) |=> ($stable(ctrl) && $stable(reload)));

  // R2
  ctrl_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && hit_ctrl) |=> (16'(ctrl) ==
      {$past(wdata[15:8]), 2'b00, $past(wdata[5:2]), 1'b0, $past(wdata[0])}));
endmodule

// File: rtl/wdog_tick.sv
module wdog_tick
  import wdog_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [PRE_W-1:0] pre,
  input  logic [1:0]       div_sel,
  output logic             tick
);
  logic [PRE_W-1:0] pc;
  logic [DIV_W-1:0] dc;
  logic [DIV_W-1:0] mask;
  logic             pre_wrap;

  assign mask     = div_mask(div_sel);
  assign pre_wrap = (pc >= pre);
  assign tick     = en && pre_wrap && ((dc & mask) == mask);

  // Held at zero while disabled, so a rising enable starts from a clean state.
  always_ff @(posedge clk) begin
    if (rst || !en) begin
      pc <= '0;
      dc <= '0;
    end else if (pre_wrap) begin
      pc <= '0;
      dc <= (dc + 1'b1) & mask;
    end else begin
      pc <= pc + 1'b1;
    end
  end

  // R4
  enable_rise_clean_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(en) |-> (pc == '0 && dc == '0));
endmodule

// File: rtl/wdog_core.sv
module wdog_core #(
  parameter int CNT_W      = 16,
  parameter int RST_CYCLES = 128
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_wdata,
  input  logic [CNT_W-1:0] reload,
  input  logic             int_en,
  input  logic             rst_en,
  input  logic             irq_clr,
  output logic [CNT_W-1:0] cnt,
  output logic             expire,
  output logic             irq,
  output logic             rst_req
);
  localparam int RW = $clog2(RST_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_INIT = CNT_W'(1) << (CNT_W - 1);

  logic [RW-1:0] rst_left;

  assign expire  = tick && !cnt_wr && (cnt == '0);
  assign rst_req = (rst_left != '0);

  always_ff @(posedge clk) begin
    if (rst)         cnt <= CNT_INIT;
    else if (cnt_wr) cnt <= cnt_wdata;
    else if (expire) cnt <= reload;
    else if (tick)   cnt <= cnt - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)                  irq <= 1'b0;
    else if (expire && int_en) irq <= 1'b1;
    else if (irq_clr)         irq <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst)                   rst_left <= '0;
    else if (expire && rst_en) rst_left <= RW'(RST_CYCLES);
    else if (rst_left != '0)   rst_left <= rst_left - 1'b1;
  end

  // R5
  cnt_load_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_wr |=> (cnt == $past(cnt_wdata)));

  // R6
  reload_chk: assert property (@(posedge clk) disable iff (rst)
    expire |=> (cnt == $past(reload)));

  // R7
  irq_set_chk: assert property (@(posedge clk) disable iff (rst)
    (expire && int_en) |=> irq);

  // R7
  irq_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (irq && !irq_clr) |=> irq);

  // R8
  rst_start_chk: assert property (@(posedge clk) disable iff (rst)
    (expire && rst_en) |=> rst_req);

  // R10
  rst_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rst_req) |-> $past(expire && rst_en));
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 16,
  parameter int CNT_W      = 16,
  parameter int RST_CYCLES = 128
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq,
  output logic              rst_req
);
  ctrl_t            ctrl;
  logic [CNT_W-1:0] reload;
  logic [CNT_W-1:0] cnt;
  logic             cnt_wr;
  logic             irq_clr;
  logic             tick;
  logic             expire;

  wdog_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wdata(wdata),
    .cnt_val(cnt), .ctrl(ctrl), .reload(reload), .cnt_wr(cnt_wr),
    .irq_clr(irq_clr), .rdata(rdata)
  );

  wdog_tick u_tick (
    .clk(clk), .rst(rst), .en(ctrl.en), .pre(ctrl.pre),
    .div_sel(ctrl.div_sel), .tick(tick)
  );

  wdog_core #(.CNT_W(CNT_W), .RST_CYCLES(RST_CYCLES)) u_core (
    .clk(clk), .rst(rst), .tick(tick), .cnt_wr(cnt_wr),
    .cnt_wdata(wdata[CNT_W-1:0]), .reload(reload), .int_en(ctrl.int_en),
    .rst_en(ctrl.rst_en), .irq_clr(irq_clr), .cnt(cnt), .expire(expire),
    .irq(irq), .rst_req(rst_req)
  );

  // R9
  halt_when_off_chk: assert property (@(posedge clk) disable iff (rst)
    (!ctrl.en && !cnt_wr) |=> $stable(cnt));
endmodule

// File: tb/wdog_timer_tb.sv
module wdog_timer_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  addr = 8'h00;
  logic        wr_en = 1'b0;
  logic [15:0] wdata = 16'h0000;
  logic [15:0] rdata;
  logic        irq, rst_req;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  localparam logic [7:0] A_CTL = 8'h00, A_RLD = 8'h04, A_CNT = 8'h08;

  wdog_timer u_dut (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wdata(wdata),
    .rdata(rdata), .irq(irq), .rst_req(rst_req)
  );

  always #2 clk = ~clk;

  // Step period restated: prescale ratio times divider ratio.
  function automatic int step_period(input int p, input int s);
    int ratio;
    ratio = 16;
    for (int k = 0; k < s; k++) ratio = ratio * 2;
    return (p + 1) * ratio;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [15:0] v);
    addr = a;
    #1;
    v = rdata;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    void'($urandom(32'd1234));
    wait_n(3);
    rst = 1'b0;

    // R1 reset values
    rd(A_CTL, v); chk("R1 ctrl", v, 16'h8021);
    rd(A_RLD, v); chk("R1 reload", v, 16'h8000);
    rd(A_CNT, v); chk("R1 count", v, 16'h8000);
    chk("R1 irq", irq, 1'b0);
    chk("R1 rst_req", rst_req, 1'b0);

    wr(A_CTL, 16'h0000);

    // R3 unmapped offsets
    rd(8'h0C, v); chk("R3 read 0x0C", v, 16'h0000);
    rd(8'h01, v); chk("R3 read 0x01", v, 16'h0000);
    wr(8'h0C, 16'hFFFF);
    wr(8'h05, 16'h1111);
    rd(A_CTL, v); chk("R3 ctrl kept", v, 16'h0000);
    rd(A_RLD, v); chk("R3 reload kept", v, 16'h8000);

    // R9 halted while disabled
    wait_n(40);
    rd(A_CNT, v); chk("R9 halt", v, 16'h8000);

    // R2 field map, pads and clear bit read as 0
    wr(A_CTL, 16'hFFDE);
    rd(A_CTL, v); chk("R2 ctrl fields", v, 16'hFF1C);
    wr(A_CTL, 16'h0000);
    wr(A_RLD, 16'h0005);
    rd(A_RLD, v); chk("R2 reload", v, 16'h0005);

    // R4 period, R6 reload, R7 irq, R10 no reset
    wr(A_CNT, 16'h0003);
    wr(A_CTL, 16'h0024);
    wait_n(15); rd(A_CNT, v); chk("R4 before first step", v, 16'h0003);
    wait_n(1);  rd(A_CNT, v); chk("R4 first step", v, 16'h0002);
    wait_n(47); rd(A_CNT, v); chk("R6 at zero", v, 16'h0000);
    chk("R7 irq before expiry", irq, 1'b0);
    wait_n(1);  rd(A_CNT, v); chk("R6 reload on expiry", v, 16'h0005);
    chk("R7 irq set", irq, 1'b1);
    chk("R10 no rst_req", rst_req, 1'b0);
    wait_n(20); chk("R7 irq sticky", irq, 1'b1);
    wr(A_CTL, 16'h0026);
    chk("R7 irq cleared", irq, 1'b0);
    wr(A_CTL, 16'h0000);

    // R5 write wins over a coincident tick
    wr(A_CNT, 16'h0040);
    wr(A_CTL, 16'h0020);
    wait_n(15);
    wr(A_CNT, 16'h0100);
    rd(A_CNT, v); chk("R5 write beats tick", v, 16'h0100);
    wait_n(16); rd(A_CNT, v); chk("R5 next step", v, 16'h00FF);
    wr(A_CTL, 16'h0000);

    // R8 reset pulse length, R10 no irq
    wr(A_RLD, 16'h0002);
    wr(A_CNT, 16'h0000);
    wr(A_CTL, 16'h0021);
    wait_n(15); chk("R8 before expiry", rst_req, 1'b0);
    wait_n(1);  chk("R8 pulse start", rst_req, 1'b1);
    chk("R10 no irq", irq, 1'b0);
    rd(A_CNT, v); chk("R6 reload 2", v, 16'h0002);
    wr(A_CTL, 16'h0001);
    wait_n(126); chk("R8 last pulse clock", rst_req, 1'b1);
    wait_n(1);   chk("R8 pulse end", rst_req, 1'b0);

    // R9 fully disarmed
    wr(A_CTL, 16'h0000);
    wait_n(300);
    chk("R9 disarmed rst_req", rst_req, 1'b0);
    rd(A_CNT, v); chk("R9 disarmed count", v, 16'h0002);

    // R7 and R8 together
    wr(A_CNT, 16'h0000);
    wr(A_CTL, 16'h0025);
    wait_n(16);
    chk("R7 both irq", irq, 1'b1);
    chk("R8 both rst_req", rst_req, 1'b1);
    wr(A_CTL, 16'h0002);
    chk("R7 clear while off", irq, 1'b0);
    wait_n(200);

    // R4 random prescale/divider, R3 random stray writes
    for (int i = 0; i < 10; i++) begin
      int p, s, n;
      logic [15:0] c;
      logic [7:0]  sa;
      p = $urandom % 6;
      s = $urandom % 4;
      c = 16'(100 + ($urandom % 50));
      sa = 8'(($urandom % 60) * 4 + 12);
      wr(sa, 16'($urandom));
      rd(A_RLD, v); chk("R3 random stray", v, 16'h0002);
      n = step_period(p, s);
      wr(A_CNT, c);
      wr(A_CTL, {8'(p), 3'b001, 2'(s), 3'b000});
      wait_n(n - 1); rd(A_CNT, v); chk("R4 random hold", v, c);
      wait_n(1);     rd(A_CNT, v); chk("R4 random step", v, c - 16'd1);
      wr(A_CTL, 16'h0000);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule